// File: doc/BRIEF.md
# SPI Register Access Master

This block is the host-side master for an external peripheral that exposes its registers over SPI. Every access is one frame: a 16-bit command word, then one or more 16-bit data words for consecutive register addresses. Slave select stays low for the whole frame. Words go out MSB first. MOSI changes on the rising SCLK edge and MISO is sampled on the falling edge, with SCLK idling low.

The host loads words one at a time through a ready/load handshake. The first word loaded while no frame is open is the command. The read flag and the word count are sampled with it. In a write frame the host supplies each data word. In a read frame the block shifts out zeros after the command and returns each captured word through a receive-full flag, which the host clears with a take strobe. The SCLK period is `clk_div + 1` system clocks, so a field of 199 gives a divide ratio of 200. After enable the block waits a fixed number of SCLK periods before it accepts anything.

Top module: `spi_regacc_master`

## Requirements
- R1: After reset, and whenever no frame is in progress, ss_n is 1, sclk is 0 and mosi is 0. tx_ready and rx_full are 0 after reset.
- R2: tx_ready stays 0 while enable is 0. After enable rises it stays 0 for SETTLE_SCLKS (2) full SCLK periods: with clk_div = 3 it is first seen high 8 clocks after the first edge that samples enable high.
- R3: The SCLK period is clk_div + 1 system clocks. mosi changes only together with a rising sclk or with ss_n returning high. The peripheral's MISO is sampled when sclk falls.
- R4: A frame carries the command word and then the data words, each MSB first, with ss_n low from the first bit to the last. Command 0x1000 with data 0x0200 appears on mosi as exactly 0x10000200.
- R5: The first rising sclk edge comes one full SCLK period after ss_n falls.
- R6: ss_n returns high half an SCLK period after the last falling edge, at the next rising-edge slot. No extra sclk pulse is produced.
- R7: In a read frame (cmd_read = 1) every data word is shifted out as 0x0000. tx_ready stays 0 for the rest of the frame, and a tx_load made while tx_ready is 0 has no effect on mosi.
- R8: In a read frame each data word is assembled MSB first from miso, placed on rx_data, and flagged by rx_full. The miso bits received during the command word are never posted.
- R9: rx_take clears rx_full on the next clock, unless a new word is captured in that same cycle.
- R10: A tx_load accepted while tx_ready is 1 drops tx_ready on the next clock until that word starts shifting. If a write data word has not been loaded when it is due, the frame pauses with ss_n low and sclk low, then resumes with the correct bits.
- R11: Dropping enable aborts any frame. On the next clock ss_n is 1, sclk and mosi are 0 and tx_ready is 0.
- R12: cmd_count is the number of data words minus one. A frame is therefore 16 × (cmd_count + 2) bits long.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| enable | input | 1 | Runs the clock generator and the shifter; low aborts and idles |
| clk_div | input | DIV_W | SCLK period minus one, in system clocks (minimum 1) |
| tx_load | input | 1 | Loads tx_word when tx_ready is 1 |
| tx_word | input | 16 | Command or write data word |
| cmd_read | input | 1 | Sampled with a command: 1 selects a read frame |
| cmd_count | input | CNT_W | Sampled with a command: data words minus one |
| tx_ready | output | 1 | A word may be loaded |
| rx_take | input | 1 | Host has consumed rx_data |
| rx_data | output | 16 | Last word captured in a read frame |
| rx_full | output | 1 | rx_data holds an unconsumed word |
| ss_n | output | 1 | Active-low slave select |
| sclk | output | 1 | Serial clock, idles low |
| mosi | output | 1 | Serial data to the peripheral |
| miso | input | 1 | Serial data from the peripheral |

## Verification
The most telling faults are a bit counter or word index that drifts. It shows within the same frame as a mosi capture of the wrong length or an ss_n rise at the wrong slot, one SCLK period after the fault at most. A wrong divider or lead state shows as a lead or tail gap that differs from 4 and 2 system clocks at clk_div = 3. That is visible on the first frame. A handshake fault shows either as tx_ready staying high after a load, on the very next clock, or as loaded data leaking into a read frame. A fault in the receive path shows as a wrong rx_data, or as the command-phase pattern being posted, when the first read word completes.

// File: rtl/spi_regacc_pkg.sv
// Shared definitions for the SPI register access master.
// Assumes 16-bit words on the serial line for both command and data.
package spi_regacc_pkg;
    localparam int WORD_W = 16;
    localparam int BIT_W  = $clog2(WORD_W);

    typedef enum logic [1:0] {
        ENG_IDLE,
        ENG_LEAD,
        ENG_SHIFT,
        ENG_TAIL
    } eng_state_t;
endpackage

// File: rtl/spi_regacc_clkgen.sv
// SCLK slot generator: a free-running phase counter that marks one
// rising-edge slot and one falling-edge slot per SCLK period.
// Assumes div >= 1 so that the two slots never coincide.
module spi_regacc_clkgen #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] div,
    output logic             rise_tick,
    output logic             fall_tick
);
    logic [DIV_W-1:0] phase;

    // Phase counter wraps every div+1 clocks while running.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            phase <= '0;
        end else if (phase >= div) begin
            phase <= '0;
        end else begin
            phase <= phase + 1'b1;
        end
    end

    // Slot decode: rise at the end of the period, fall near the middle.
    always_comb begin
        rise_tick = run && (phase == div);
        fall_tick = run && (phase == (div >> 1));
    end
endmodule

// File: rtl/spi_regacc_settle.sv
// Start-up settle timer: counts SCLK periods after enable and raises
// settled once SETTLE_SCLKS rising-edge slots have passed.
// Assumes rise_tick occurs once per SCLK period.
module spi_regacc_settle #(
    parameter int SETTLE_SCLKS = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic rise_tick,
    output logic settled
);
    localparam int SW = $clog2(SETTLE_SCLKS + 1);

    logic [SW-1:0] periods;

    // Count periods until the settle interval has elapsed.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            periods <= '0;
            settled <= 1'b0;
        end else if (rise_tick && !settled) begin
            periods <= periods + 1'b1;
            if (periods == SW'(SETTLE_SCLKS - 1)) begin
                settled <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/spi_regacc_txbuf.sv
// Host-side word buffer and frame bookkeeping. The first word loaded while
// no frame is open is the command; read flag and count are latched with it.
// Assumes the engine consumes the buffer only when it is full.
module spi_regacc_txbuf #(
    parameter int CNT_W = 4
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic                                run,
    input  logic                                settled,
    input  logic                                tx_load,
    input  logic [spi_regacc_pkg::WORD_W-1:0]   tx_word,
    input  logic                                cmd_read,
    input  logic [CNT_W-1:0]                    cmd_count,
    input  logic                                consume,
    input  logic                                frame_end,
    output logic                                tx_ready,
    output logic [spi_regacc_pkg::WORD_W-1:0]   buf_word,
    output logic                                buf_full,
    output logic                                frame_open,
    output logic                                frame_read,
    output logic [CNT_W-1:0]                    frame_cnt
);
    localparam int LW = CNT_W + 1;

    logic [LW-1:0] load_left;

    // Ready when settled, buffer empty, and the frame still expects a word.
    always_comb begin
        tx_ready = settled && !buf_full && (!frame_open || (load_left != '0));
    end

    // Buffer fill/drain and per-frame attributes.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            buf_word   <= '0;
            buf_full   <= 1'b0;
            frame_open <= 1'b0;
            frame_read <= 1'b0;
            frame_cnt  <= '0;
            load_left  <= '0;
        end else begin
            if (frame_end) begin
                frame_open <= 1'b0;
            end
            if (consume) begin
                buf_full <= 1'b0;
            end
            if (tx_load && tx_ready) begin
                buf_word <= tx_word;
                buf_full <= 1'b1;
                if (!frame_open) begin
                    frame_open <= 1'b1;
                    frame_read <= cmd_read;
                    frame_cnt  <= cmd_count;
                    load_left  <= cmd_read ? '0 : ({1'b0, cmd_count} + LW'(1));
                end else begin
                    load_left <= load_left - 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/spi_regacc_engine.sv
// Serial frame engine: drives ss_n, sclk and mosi in the rising-edge slot,
// samples miso in the falling-edge slot, and posts read words to the host.
// Assumes one rise slot and one fall slot per SCLK period, never together.
module spi_regacc_engine #(
    parameter int CNT_W = 4
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic                                run,
    input  logic                                rise_tick,
    input  logic                                fall_tick,
    input  logic [spi_regacc_pkg::WORD_W-1:0]   buf_word,
    input  logic                                buf_full,
    input  logic                                frame_open,
    input  logic                                frame_read,
    input  logic [CNT_W-1:0]                    frame_cnt,
    input  logic                                miso,
    input  logic                                rx_take,
    output logic                                consume,
    output logic                                frame_end,
    output logic                                ss_n,
    output logic                                sclk,
    output logic                                mosi,
    output logic [spi_regacc_pkg::WORD_W-1:0]   rx_data,
    output logic                                rx_full
);
    import spi_regacc_pkg::*;

    localparam int LW = CNT_W + 1;

    eng_state_t        state;
    logic [WORD_W-1:0] shreg;
    logic [WORD_W-1:0] rxsh;
    logic [BIT_W-1:0]  bit_cnt;
    logic [LW-1:0]     word_idx;
    logic              word_start;
    logic [LW-1:0]     last_idx;

    // Index of the final word of the frame (command is index 0).
    always_comb begin
        last_idx = {1'b0, frame_cnt} + LW'(1);
    end

    // Buffer consumption and end-of-frame strobes.
    always_comb begin
        consume   = 1'b0;
        frame_end = 1'b0;
        if (state == ENG_IDLE && rise_tick && buf_full && frame_open) begin
            consume = 1'b1;
        end
        if (state == ENG_SHIFT && rise_tick && !sclk && word_start
            && !frame_read && buf_full) begin
            consume = 1'b1;
        end
        if (state == ENG_TAIL && rise_tick) begin
            frame_end = 1'b1;
        end
    end

    // Frame sequencing, shifting and receive posting.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            state      <= ENG_IDLE;
            ss_n       <= 1'b1;
            sclk       <= 1'b0;
            mosi       <= 1'b0;
            shreg      <= '0;
            rxsh       <= '0;
            bit_cnt    <= '0;
            word_idx   <= '0;
            word_start <= 1'b0;
            rx_data    <= '0;
            rx_full    <= 1'b0;
        end else begin
            if (rx_take) begin
                rx_full <= 1'b0;
            end
            case (state)
                ENG_IDLE: begin
                    if (consume) begin
                        shreg    <= buf_word;
                        ss_n     <= 1'b0;
                        word_idx <= '0;
                        state    <= ENG_LEAD;
                    end
                end
                ENG_LEAD: begin
                    if (rise_tick) begin
                        sclk       <= 1'b1;
                        mosi       <= shreg[WORD_W-1];
                        bit_cnt    <= '0;
                        word_start <= 1'b0;
                        state      <= ENG_SHIFT;
                    end
                end
                ENG_SHIFT: begin
                    if (rise_tick && !sclk) begin
                        if (word_start) begin
                            if (frame_read) begin
                                shreg      <= '0;
                                mosi       <= 1'b0;
                                sclk       <= 1'b1;
                                word_start <= 1'b0;
                            end else if (buf_full) begin
                                shreg      <= buf_word;
                                mosi       <= buf_word[WORD_W-1];
                                sclk       <= 1'b1;
                                word_start <= 1'b0;
                            end
                        end else begin
                            shreg <= {shreg[WORD_W-2:0], 1'b0};
                            mosi  <= shreg[WORD_W-2];
                            sclk  <= 1'b1;
                        end
                    end
                    if (fall_tick && sclk) begin
                        sclk    <= 1'b0;
                        rxsh    <= {rxsh[WORD_W-2:0], miso};
                        bit_cnt <= bit_cnt + 1'b1;
                        if (bit_cnt == BIT_W'(WORD_W - 1)) begin
                            if (frame_read && word_idx != '0) begin
                                rx_data <= {rxsh[WORD_W-2:0], miso};
                                rx_full <= 1'b1;
                            end
                            if (word_idx == last_idx) begin
                                state <= ENG_TAIL;
                            end else begin
                                word_idx   <= word_idx + 1'b1;
                                word_start <= 1'b1;
                            end
                        end
                    end
                end
                ENG_TAIL: begin
                    if (rise_tick) begin
                        ss_n  <= 1'b1;
                        mosi  <= 1'b0;
                        state <= ENG_IDLE;
                    end
                end
                default: state <= ENG_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/spi_regacc_master.sv
// SPI register access master top level: ties the slot generator, settle
// timer, host word buffer and serial engine together.
// Assumes clk_div >= 1 and a single peripheral on the bus.
module spi_regacc_master #(
    parameter int DIV_W        = 8,
    parameter int CNT_W        = 4,
    parameter int SETTLE_SCLKS = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic [DIV_W-1:0]  clk_div,
    input  logic              tx_load,
    input  logic [15:0]       tx_word,
    input  logic              cmd_read,
    input  logic [CNT_W-1:0]  cmd_count,
    output logic              tx_ready,
    input  logic              rx_take,
    output logic [15:0]       rx_data,
    output logic              rx_full,
    output logic              ss_n,
    output logic              sclk,
    output logic              mosi,
    input  logic              miso
);
    logic        rise_tick;
    logic        fall_tick;
    logic        settled;
    logic        consume;
    logic        frame_end;
    logic [15:0] buf_word;
    logic        buf_full;
    logic        frame_open;
    logic        frame_read;
    logic [CNT_W-1:0] frame_cnt;

    spi_regacc_clkgen #(.DIV_W(DIV_W)) u_clkgen (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (enable),
        .div       (clk_div),
        .rise_tick (rise_tick),
        .fall_tick (fall_tick)
    );

    spi_regacc_settle #(.SETTLE_SCLKS(SETTLE_SCLKS)) u_settle (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (enable),
        .rise_tick (rise_tick),
        .settled   (settled)
    );

    spi_regacc_txbuf #(.CNT_W(CNT_W)) u_txbuf (
        .clk        (clk),
        .rst_n      (rst_n),
        .run        (enable),
        .settled    (settled),
        .tx_load    (tx_load),
        .tx_word    (tx_word),
        .cmd_read   (cmd_read),
        .cmd_count  (cmd_count),
        .consume    (consume),
        .frame_end  (frame_end),
        .tx_ready   (tx_ready),
        .buf_word   (buf_word),
        .buf_full   (buf_full),
        .frame_open (frame_open),
        .frame_read (frame_read),
        .frame_cnt  (frame_cnt)
    );

    spi_regacc_engine #(.CNT_W(CNT_W)) u_engine (
        .clk        (clk),
        .rst_n      (rst_n),
        .run        (enable),
        .rise_tick  (rise_tick),
        .fall_tick  (fall_tick),
        .buf_word   (buf_word),
        .buf_full   (buf_full),
        .frame_open (frame_open),
        .frame_read (frame_read),
        .frame_cnt  (frame_cnt),
        .miso       (miso),
        .rx_take    (rx_take),
        .consume    (consume),
        .frame_end  (frame_end),
        .ss_n       (ss_n),
        .sclk       (sclk),
        .mosi       (mosi),
        .rx_data    (rx_data),
        .rx_full    (rx_full)
    );
endmodule

// File: rtl/spi_regacc_chk.sv
// Protocol checker for the SPI register access master, bound to the top.
// Observes only top-level ports.
module spi_regacc_chk (
    input logic clk,
    input logic rst_n,
    input logic enable,
    input logic tx_load,
    input logic tx_ready,
    input logic ss_n,
    input logic sclk,
    input logic mosi
);
    // R1
    idle_sclk_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ss_n |-> !sclk);

    // R1
    idle_mosi_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ss_n |-> !mosi);

    // R3
    mosi_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(mosi) |-> ($rose(sclk) || $rose(ss_n)));

    // R4
    sclk_in_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sclk) |-> !ss_n);

    // R5
    lead_no_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ss_n) |-> !sclk);

    // R10
    load_clears_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_load && tx_ready) |=> !tx_ready);

    // R11
    abort_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (ss_n && !sclk && !tx_ready));

    // R2
    settle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(enable) |=> !tx_ready);
endmodule

bind spi_regacc_master spi_regacc_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .enable   (enable),
    .tx_load  (tx_load),
    .tx_ready (tx_ready),
    .ss_n     (ss_n),
    .sclk     (sclk),
    .mosi     (mosi)
);

// File: tb/sim_spi_regacc_master.sv
// Self-checking bench for spi_regacc_master with a simple peripheral model.
module sim_spi_regacc_master;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        enable;
    logic [7:0]  clk_div;
    logic        tx_load;
    logic [15:0] tx_word;
    logic        cmd_read;
    logic [3:0]  cmd_count;
    logic        tx_ready;
    logic        rx_take;
    logic [15:0] rx_data;
    logic        rx_full;
    logic        ss_n;
    logic        sclk;
    logic        mosi;
    logic        miso;

    always #10 clk = ~clk;

    spi_regacc_master u0 (
        .clk(clk), .rst_n(rst_n), .enable(enable), .clk_div(clk_div),
        .tx_load(tx_load), .tx_word(tx_word), .cmd_read(cmd_read),
        .cmd_count(cmd_count), .tx_ready(tx_ready), .rx_take(rx_take),
        .rx_data(rx_data), .rx_full(rx_full), .ss_n(ss_n), .sclk(sclk),
        .mosi(mosi), .miso(miso)
    );

    typedef struct packed {
        logic        rd;
        logic [3:0]  cnt;
        logic [15:0] cmd;
        logic [15:0] w0;
        logic [15:0] w1;
        logic [15:0] r0;
        logic [15:0] r1;
    } vec_t;

    localparam int NV = 4;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 4'd0, 16'h1000, 16'h0200, 16'h0000, 16'h0000, 16'h0000},
        '{1'b0, 4'd1, 16'h1360, 16'h1120, 16'hA5C3, 16'h0000, 16'h0000},
        '{1'b1, 4'd0, 16'h8040, 16'h0000, 16'h0000, 16'h3C5A, 16'h0000},
        '{1'b1, 4'd1, 16'h8060, 16'h0000, 16'h0000, 16'h1234, 16'hFEDC}
    };

    int checks = 0;
    int fails  = 0;
    bit finished = 0;

    // Peripheral-side monitor state, updated at falling clk edges.
    int          cyc = 0;
    int          nbits = 0;
    int          frames_done = 0;
    int          lead_gap = 0;
    int          tail_gap = 0;
    int          period_gap = 0;
    int          mosi_viol = 0;
    logic [63:0] cap = '0;
    logic [47:0] slave_stream = '0;
    int          ss_fall_cyc = 0;
    int          last_fall_cyc = 0;
    int          last_rise_cyc = 0;
    int          rises = 0;
    logic        p_ss = 1'b1;
    logic        p_sclk = 1'b0;
    logic        p_mosi = 1'b0;

    initial miso = 1'b0;

    always @(negedge clk) begin
        cyc++;
        if (rst_n) begin
            if (mosi !== p_mosi && !(!p_sclk && sclk) && !(!p_ss && ss_n)) mosi_viol++;
            if (p_ss && !ss_n) begin
                ss_fall_cyc = cyc; nbits = 0; cap = '0; rises = 0;
            end
            if (!p_sclk && sclk) begin
                if (rises == 0) lead_gap = cyc - ss_fall_cyc;
                if (rises == 1) period_gap = cyc - last_rise_cyc;
                last_rise_cyc = cyc;
                rises++;
                miso = (nbits < 48) ? slave_stream[47 - nbits] : 1'b0;
            end
            if (p_sclk && !sclk) begin
                cap = {cap[62:0], mosi};
                nbits++;
                last_fall_cyc = cyc;
            end
            if (!p_ss && ss_n) begin
                tail_gap = cyc - last_fall_cyc;
                frames_done++;
            end
        end
        p_ss = ss_n; p_sclk = sclk; p_mosi = mosi;
    end

    task automatic chk(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic load_word(input logic [15:0] w, input logic rd,
                             input logic [3:0] cnt);
        while (!tx_ready) @(negedge clk);
        tx_word = w; cmd_read = rd; cmd_count = cnt; tx_load = 1'b1;
        @(negedge clk);
        tx_load = 1'b0;
    endtask

    task automatic run_frame(input vec_t v, input bit stall);
        int fd;
        logic [63:0] exp;
        fd = frames_done;
        slave_stream = {16'hBEEF, v.r0, v.r1};
        load_word(v.cmd, v.rd, v.cnt);
        chk(tx_ready == 1'b0, "R10 ready drops after load", 64'(tx_ready), 64'd0);
        if (!v.rd) begin
            load_word(v.w0, 1'b0, 4'd0);
            if (v.cnt == 4'd1) begin
                if (stall) begin
                    while (nbits < 32) @(negedge clk);
                    repeat (20) @(negedge clk);
                    chk(ss_n == 1'b0 && sclk == 1'b0 && nbits == 32,
                        "R10 stall holds ss_n low, sclk low",
                        {ss_n, sclk, 62'(nbits)}, 64'd32);
                end
                load_word(v.w1, 1'b0, 4'd0);
            end
        end else begin
            // R7: stray load while tx_ready is low must not reach mosi.
            tx_word = 16'hFFFF; tx_load = 1'b1;
            @(negedge clk);
            tx_load = 1'b0;
            while (!rx_full) @(negedge clk);
            chk(rx_data == v.r0, "R8 first read word", 64'(rx_data), 64'(v.r0));
            rx_take = 1'b1;
            @(negedge clk);
            rx_take = 1'b0;
            chk(rx_full == 1'b0, "R9 take clears rx_full", 64'(rx_full), 64'd0);
            if (v.cnt == 4'd1) begin
                while (!rx_full) @(negedge clk);
                chk(rx_data == v.r1, "R8 second read word", 64'(rx_data), 64'(v.r1));
                rx_take = 1'b1;
                @(negedge clk);
                rx_take = 1'b0;
            end
        end
        while (frames_done == fd) @(negedge clk);
        if (v.cnt == 4'd0)
            exp = {32'h0, v.cmd, (v.rd ? 16'h0 : v.w0)};
        else
            exp = {16'h0, v.cmd, (v.rd ? 16'h0 : v.w0), (v.rd ? 16'h0 : v.w1)};
        chk(nbits == 16 * (int'(v.cnt) + 2), "R12 frame length",
            64'(nbits), 64'(16 * (int'(v.cnt) + 2)));
        chk(cap == exp, (v.rd ? "R7 read frame mosi bits" : "R4 frame mosi bits"),
            cap, exp);
        chk(lead_gap == 4, "R5 lead one SCLK period", 64'(lead_gap), 64'd4);
        chk(tail_gap == 2, "R6 tail half period", 64'(tail_gap), 64'd2);
        chk(period_gap == 4, "R3 SCLK period", 64'(period_gap), 64'd4);
        @(negedge clk);
        chk(ss_n == 1'b1 && sclk == 1'b0 && mosi == 1'b0, "R1 idle after frame",
            {ss_n, sclk, mosi}, 64'h4);
    endtask

    initial begin
        rst_n = 1'b0; enable = 1'b0; clk_div = 8'd3; tx_load = 1'b0;
        tx_word = '0; cmd_read = 1'b0; cmd_count = '0; rx_take = 1'b0;
        repeat (3) @(negedge clk);
        chk(ss_n == 1'b1 && sclk == 1'b0 && mosi == 1'b0, "R1 reset pins",
            {ss_n, sclk, mosi}, 64'h4);
        chk(tx_ready == 1'b0 && rx_full == 1'b0, "R1 reset flags",
            {tx_ready, rx_full}, 64'd0);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        chk(tx_ready == 1'b0, "R2 not ready while disabled", 64'(tx_ready), 64'd0);

        // R2: settle interval after enable
        enable = 1'b1;
        repeat (7) @(negedge clk);
        chk(tx_ready == 1'b0, "R2 still settling", 64'(tx_ready), 64'd0);
        @(negedge clk);
        chk(tx_ready == 1'b1, "R2 ready after settle", 64'(tx_ready), 64'd1);

        // Vector table: writes and reads, single and multi-word.
        for (int i = 0; i < NV; i++) begin
            run_frame(VECS[i], 1'b0);
        end

        // R10: multi-word write that stalls for its last data word.
        run_frame('{1'b0, 4'd1, 16'h2468, 16'h1357, 16'hC0DE, 16'h0, 16'h0}, 1'b1);

        // R11: abort mid-frame.
        slave_stream = '0;
        load_word(16'h7777, 1'b0, 4'd0);
        load_word(16'h5555, 1'b0, 4'd0);
        while (nbits < 5) @(negedge clk);
        enable = 1'b0;
        @(negedge clk);
        chk(ss_n == 1'b1 && sclk == 1'b0 && mosi == 1'b0 && tx_ready == 1'b0,
            "R11 abort idles outputs", {ss_n, sclk, mosi, tx_ready}, 64'h8);
        repeat (3) @(negedge clk);
        enable = 1'b1;
        run_frame(VECS[0], 1'b0);

        chk(mosi_viol == 0, "R3 mosi changes only at sclk rise",
            64'(mosi_viol), 64'd0);

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL watchdog all requirements actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule